// File: doc/BRIEF.md
# SPI Register Slave with Status Byte

This block is an SPI target that lets a host read and write a small internal register file over a four-wire serial link. It works in SPI mode 0: the clock idles low, data goes most significant bit first, and each frame is the time the active-low select line is held low, cut into 8-bit slots. The slave oversamples select, clock and data-in with its own system clock through a short synchronizer. In each slot it returns what it received in the slot before: the opcode, the address, and during writes the data byte. This echo lets the host confirm every command byte it sent.

Four commands exist, and each opcode value is a parameter. A burst read returns bytes from consecutive addresses, starting at the address given in the second slot. A burst write stores each incoming data byte at consecutive addresses. A status query returns an 8-bit status word. A sensor-valid query returns the state of an external validity flag. The valid address window and the reset contents of the registers are also parameters. When a burst reaches an address outside the window, the address counter stops moving and the failure is recorded in the status word. The error flag in that word covers only the most recent frame. Its other flags describe the most recent register access.

Top module: `spi_regslave`

## Requirements
- R1: Slot 0 of every frame returns 0x00. For a recognised opcode, slot 1 returns the opcode byte received in slot 0.
- R2: Burst read (opcode 0x81): slot 2 returns the address received in slot 1. Slot 3 onward return the registers at that address, address+1 and so on. The register at window index i resets to ((i*29) mod 256) XOR 0xA5. The window is addresses 0x10 to 0x1B.
- R3: Burst write (opcode 0xCF): each byte from slot 2 onward is stored at the current address, which then advances by one. Every byte is returned on MISO one slot after it was received.
- R4: When the current burst address lies outside the window, the counter stops advancing and FAIL (bit 2) is set. VALID (bit 0) is cleared, a read returns 0x00 and a write is dropped. A byte that does reach a window address sets VALID.
- R5: A burst whose start address lies outside the window sets DISMISS (bit 3) and FAIL. A burst whose start address lies inside the window clears both.
- R6: Status query (opcode 0xAD) returns the status word in slot 2 and 0x00 after it. The bits are ERROR=7, 6..4 always 0, DISMISS=3, FAIL=2, BUSY=1, VALID=0. The reset value is 0x00. BUSY is cleared when select rises, so it reads 0 in a query.
- R7: Any other opcode gives 0x00 in all later slots of that frame. It sets ERROR in the status word, and leaves bits 3..0 untouched. ERROR is rewritten at the end of every frame that completed its opcode byte, so an error-free frame clears it.
- R8: Sensor-valid query (opcode 0xF5) returns the validity input in bit 7 of slot 2, with all other bits 0. A low validity input during the query sets ERROR for that frame.
- R9: If select rises in the middle of a data byte during a burst write, FAIL is set and VALID is cleared. The partial byte is not stored, and the bytes already completed remain stored.
- R10: The MISO output enable is low while select is high. A new frame always restarts at slot 0, even if the previous frame ended mid-byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sclk | input | 1 | Serial clock, idle low, data sampled on its rising edge |
| spi_mosi | input | 1 | Serial data from host |
| sensor_ok | input | 1 | Validity flag reported by the sensor-valid query |
| spi_miso | output | 1 | Serial data to host, changes after the falling SCLK edge |
| spi_miso_oe | output | 1 | Output enable for an external tristate MISO driver |

## Verification
The bench runs bursts that start just below the window, end exactly at its top or run past it. A counter that kept incrementing or wrapped would then return real register data where 0x00 is expected, or would write beyond the window. It sends illegal opcodes between status queries to check that ERROR is set for exactly one frame and then cleared, and that DISMISS, FAIL and VALID survive unchanged. A design that cleared ERROR at the start of a query, or let a bad opcode overwrite the access flags, would show a wrong status word. A write cut off three bits into a data byte checks that FAIL is raised and no half-shifted byte is stored. The following frame then checks that the bit counter restarted at slot 0, so a misaligned counter would corrupt every echo after it.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned BIT_CW = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        PH_OP   = 2'd0,
        PH_ARG  = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        CMD_RD  = 3'd0,
        CMD_WR  = 3'd1,
        CMD_ST  = 3'd2,
        CMD_SV  = 3'd3,
        CMD_BAD = 3'd4
    } cmd_e;

    typedef struct packed {
        logic       error;
        logic [2:0] rsvd;
        logic       dismiss;
        logic       fail;
        logic       busy;
        logic       valid;
    } status_t;

    localparam status_t STATUS_RESET = '0;

    function automatic cmd_e decode_op(input logic [7:0] op,
                                       input logic [7:0] op_rd,
                                       input logic [7:0] op_wr,
                                       input logic [7:0] op_st,
                                       input logic [7:0] op_sv);
        if (op == op_rd) return CMD_RD;
        if (op == op_wr) return CMD_WR;
        if (op == op_st) return CMD_ST;
        if (op == op_sv) return CMD_SV;
        return CMD_BAD;
    endfunction

    function automatic logic addr_in_window(input logic [7:0] a,
                                            input logic [7:0] first,
                                            input int unsigned count);
        return (a >= first) && ((32'(a) - 32'(first)) < count);
    endfunction

    function automatic logic [7:0] init_value(input int unsigned idx,
                                              input logic [7:0] mul,
                                              input logic [7:0] xmask);
        return 8'(idx * 32'(mul)) ^ xmask;
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int unsigned     W       = 3,
    parameter int unsigned     STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_bitio.sv
module spi_bitio
    import spi_regslave_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] tx_next,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              partial,
    output logic              frame_end,
    output logic              miso
);
    logic              sclk_q;
    logic              cs_q;
    logic [BIT_CW-1:0] bit_cnt;
    logic [BYTE_W-2:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              have_byte;
    logic              rise;
    logic              fall;

    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

    assign rise      = !cs_n_s && sclk_s && !sclk_q;
    assign fall      = !cs_n_s && !sclk_s && sclk_q;
    assign frame_end = cs_n_s && !cs_q;
    assign byte_done = rise && (bit_cnt == LAST_BIT);
    assign rx_byte   = {rx_sh, mosi_s};
    assign partial   = (bit_cnt != '0);
    assign miso      = tx_sh[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q    <= 1'b0;
            cs_q      <= 1'b1;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            have_byte <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            cs_q   <= cs_n_s;
            if (cs_n_s) begin
                bit_cnt   <= '0;
                rx_sh     <= '0;
                tx_sh     <= '0;
                have_byte <= 1'b0;
            end else begin
                if (rise) begin
                    rx_sh   <= {rx_sh[BYTE_W-3:0], mosi_s};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) have_byte <= 1'b1;
                end
                if (fall) begin
                    if (bit_cnt == '0 && have_byte) tx_sh <= tx_next;
                    else                            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
    import spi_regslave_pkg::*;
#(
    parameter logic [7:0]  FIRST    = 8'h10,
    parameter int unsigned COUNT    = 12,
    parameter logic [7:0]  INIT_MUL = 8'h1D,
    parameter logic [7:0]  INIT_XOR = 8'hA5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] waddr,
    input  logic [7:0] wdata,
    input  logic [7:0] raddr,
    output logic [7:0] rdata
);
    localparam int unsigned IDX_W = (COUNT > 1) ? $clog2(COUNT) : 1;

    logic [7:0]       mem [COUNT];
    logic [IDX_W-1:0] widx;
    logic [IDX_W-1:0] ridx;
    logic [7:0]       woff;
    logic [7:0]       roff;

    assign woff = waddr - FIRST;
    assign roff = raddr - FIRST;
    assign widx = IDX_W'(woff);
    assign ridx = IDX_W'(roff);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < COUNT; i++) mem[i] <= init_value(i, INIT_MUL, INIT_XOR);
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = (32'(ridx) < COUNT) ? mem[ridx] : 8'h00;
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
    import spi_regslave_pkg::*;
#(
    parameter logic [7:0]  OP_RD       = 8'h81,
    parameter logic [7:0]  OP_WR       = 8'hCF,
    parameter logic [7:0]  OP_ST       = 8'hAD,
    parameter logic [7:0]  OP_SV       = 8'hF5,
    parameter logic [7:0]  REG_FIRST   = 8'h10,
    parameter int unsigned REG_COUNT   = 12,
    parameter logic [7:0]  INIT_MUL    = 8'h1D,
    parameter logic [7:0]  INIT_XOR    = 8'hA5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_cs_n,
    input  logic spi_sclk,
    input  logic spi_mosi,
    input  logic sensor_ok,
    output logic spi_miso,
    output logic spi_miso_oe
);
    logic [2:0] sync_q;
    logic       cs_n_s;
    logic       sclk_s;
    logic       mosi_s;

    logic       byte_done;
    logic [7:0] rx_byte;
    logic       partial;
    logic       frame_end;

    phase_e     phase_q;
    cmd_e       cmd_q;
    logic [7:0] addr_q;
    logic [7:0] tx_next_q;
    logic       err_frame_q;
    status_t    status_q;

    logic       addr_ok;
    logic       arg_ok;
    logic       burst_cmd;
    logic       reg_we;
    logic [7:0] reg_rdata;
    cmd_e       op_cmd;

    spi_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_cs_n, spi_sclk, spi_mosi}),
        .q   (sync_q)
    );

    assign {cs_n_s, sclk_s, mosi_s} = sync_q;

    spi_bitio u_bitio (
        .clk       (clk),
        .rst       (rst),
        .cs_n_s    (cs_n_s),
        .sclk_s    (sclk_s),
        .mosi_s    (mosi_s),
        .tx_next   (tx_next_q),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .partial   (partial),
        .frame_end (frame_end),
        .miso      (spi_miso)
    );

    assign spi_miso_oe = !cs_n_s;

    assign addr_ok   = addr_in_window(addr_q, REG_FIRST, REG_COUNT);
    assign arg_ok    = addr_in_window(rx_byte, REG_FIRST, REG_COUNT);
    assign op_cmd    = decode_op(rx_byte, OP_RD, OP_WR, OP_ST, OP_SV);
    assign burst_cmd = (cmd_q == CMD_RD) || (cmd_q == CMD_WR);
    assign reg_we    = byte_done && (phase_q == PH_DATA) && (cmd_q == CMD_WR) && addr_ok;

    spi_regfile #(
        .FIRST    (REG_FIRST),
        .COUNT    (REG_COUNT),
        .INIT_MUL (INIT_MUL),
        .INIT_XOR (INIT_XOR)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .waddr (addr_q),
        .wdata (rx_byte),
        .raddr (addr_q),
        .rdata (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_OP;
            cmd_q       <= CMD_BAD;
            addr_q      <= '0;
            tx_next_q   <= '0;
            err_frame_q <= 1'b0;
            status_q    <= STATUS_RESET;
        end else if (frame_end) begin
            if (phase_q != PH_OP) status_q.error <= err_frame_q;
            status_q.busy <= 1'b0;
            if (cmd_q == CMD_WR && phase_q == PH_DATA && partial) begin
                status_q.fail  <= 1'b1;
                status_q.valid <= 1'b0;
            end
            phase_q     <= PH_OP;
            tx_next_q   <= '0;
            err_frame_q <= 1'b0;
        end else if (byte_done) begin
            case (phase_q)
                PH_OP: begin
                    cmd_q       <= op_cmd;
                    tx_next_q   <= (op_cmd == CMD_BAD) ? 8'h00 : rx_byte;
                    err_frame_q <= (op_cmd == CMD_BAD);
                    phase_q     <= PH_ARG;
                end
                PH_ARG: begin
                    phase_q <= PH_DATA;
                    case (cmd_q)
                        CMD_RD, CMD_WR: begin
                            addr_q           <= rx_byte;
                            tx_next_q        <= rx_byte;
                            status_q.dismiss <= !arg_ok;
                            status_q.fail    <= !arg_ok;
                            status_q.valid   <= 1'b0;
                            status_q.busy    <= 1'b1;
                        end
                        CMD_ST: tx_next_q <= status_q;
                        CMD_SV: begin
                            tx_next_q <= {sensor_ok, 7'b0};
                            if (!sensor_ok) err_frame_q <= 1'b1;
                        end
                        default: tx_next_q <= 8'h00;
                    endcase
                end
                default: begin
                    if (burst_cmd) begin
                        if (addr_ok) begin
                            addr_q         <= addr_q + 8'd1;
                            status_q.valid <= 1'b1;
                        end else begin
                            status_q.fail  <= 1'b1;
                            status_q.valid <= 1'b0;
                        end
                        if (cmd_q == CMD_RD) tx_next_q <= addr_ok ? reg_rdata : 8'h00;
                        else                 tx_next_q <= rx_byte;
                    end else begin
                        tx_next_q <= 8'h00;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk
    import spi_regslave_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       spi_cs_n,
    input logic       spi_miso_oe,
    input logic       byte_done,
    input logic       frame_end,
    input phase_e     phase,
    input cmd_e       cmd,
    input logic [7:0] addr,
    input logic       addr_ok,
    input status_t    status
);
    logic burst_data;
    assign burst_data = byte_done && (phase == PH_DATA) && (cmd == CMD_RD || cmd == CMD_WR);

    AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso_oe); // R10

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (burst_data && addr_ok) |=> (addr == $past(addr) + 8'd1)); // R2

    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (burst_data && !addr_ok) |=> $stable(addr)); // R4

    AST_VALID_NOT_FAIL: assert property (@(posedge clk) disable iff (rst)
        status.valid |-> !status.fail); // R4

    AST_DISMISS_FAIL: assert property (@(posedge clk) disable iff (rst)
        status.dismiss |-> status.fail); // R5

    AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !status.busy); // R6
endmodule

bind spi_regslave spi_regslave_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .spi_cs_n    (spi_cs_n),
    .spi_miso_oe (spi_miso_oe),
    .byte_done   (byte_done),
    .frame_end   (frame_end),
    .phase       (phase_q),
    .cmd         (cmd_q),
    .addr        (addr_q),
    .addr_ok     (addr_ok),
    .status      (status_q)
);

// File: tb/spi_regslave_bench.sv
`timescale 1ns/1ps
module spi_regslave_bench;
    localparam int HALF  = 6;
    localparam int FIRST = 'h10;
    localparam int COUNT = 12;
    localparam logic [7:0] OP_RD = 8'h81, OP_WR = 8'hCF, OP_ST = 8'hAD, OP_SV = 8'hF5;

    logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, sens = 1'b1;
    logic miso, oe;

    int checks = 0, errors = 0;
    logic [7:0] mem_m [COUNT];
    logic m_err = 0, m_dis = 0, m_fail = 0, m_valid = 0;
    logic [7:0] txb [32];
    logic [7:0] rxb [32];
    logic [7:0] exb [32];

    always #2.5 clk = ~clk;

    spi_regslave u_spi_regslave (
        .clk (clk), .rst (rst), .spi_cs_n (cs_n), .spi_sclk (sclk), .spi_mosi (mosi),
        .sensor_ok (sens), .spi_miso (miso), .spi_miso_oe (oe)
    );

    function automatic logic win(input int a);
        return (a >= FIRST) && (a < FIRST + COUNT);
    endfunction

    function automatic logic [7:0] st_byte();
        return {m_err, 3'b000, m_dis, m_fail, 1'b0, m_valid};
    endfunction

    task automatic clk_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check1(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h exp %02h", tag, got, exp);
        end
    endtask

    task automatic shift_byte(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int b = 7; b > 7 - nbits; b--) begin
            mosi = tx[b];
            clk_wait(HALF);
            rx[b] = miso;
            sclk = 1'b1;
            clk_wait(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic run_frame(input int n);
        cs_n = 1'b0;
        clk_wait(HALF);
        for (int i = 0; i < n; i++) shift_byte(txb[i], 8, rxb[i]);
        clk_wait(HALF);
        cs_n = 1'b1;
        clk_wait(8);
    endtask

    task automatic model_frame(input int n);
        logic bad, ferr;
        logic [7:0] op;
        int a;
        for (int i = 0; i < 32; i++) exb[i] = 8'h00;
        op   = txb[0];
        bad  = !(op == OP_RD || op == OP_WR || op == OP_ST || op == OP_SV);
        ferr = bad;
        exb[1] = bad ? 8'h00 : op;
        a = txb[1];
        if (op == OP_RD || op == OP_WR) begin
            exb[2] = txb[1];
            m_dis = !win(a); m_fail = !win(a); m_valid = 1'b0;
            for (int k = 2; k < n; k++) begin
                if (win(a)) begin
                    if (op == OP_RD) exb[k+1] = mem_m[a - FIRST];
                    else mem_m[a - FIRST] = txb[k];
                    a++;
                    m_valid = 1'b1;
                end else begin
                    if (op == OP_RD) exb[k+1] = 8'h00;
                    m_fail = 1'b1; m_valid = 1'b0;
                end
                if (op == OP_WR) exb[k+1] = txb[k];
            end
        end else if (op == OP_ST) begin
            exb[2] = st_byte();
        end else if (op == OP_SV) begin
            exb[2] = {sens, 7'b0};
            if (!sens) ferr = 1'b1;
        end
        m_err = ferr;
    endtask

    task automatic do_frame(input int n, input string tag);
        int bad_i;
        model_frame(n);
        run_frame(n);
        bad_i = -1;
        for (int i = 0; i < n; i++) if (bad_i < 0 && rxb[i] !== exb[i]) bad_i = i;
        checks++;
        if (bad_i >= 0) begin
            errors++;
            $display("FAIL %s slot %0d got %02h exp %02h", tag, bad_i, rxb[bad_i], exb[bad_i]);
        end
    endtask

    task automatic set_tx(input logic [7:0] b0, input logic [7:0] b1, input int n, input logic [7:0] fill);
        txb[0] = b0; txb[1] = b1;
        for (int i = 2; i < n; i++) txb[i] = fill + 8'(i * 17);
    endtask

    initial begin : watchdog
        clk_wait(190000);
        errors++; checks++;
        $display("FAIL watchdog expired (got hang, exp finish)");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] r;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < COUNT; i++) mem_m[i] = 8'(i * 29) ^ 8'hA5;
        clk_wait(10);
        rst = 1'b0;
        clk_wait(4);

        check1("R10 oe idle", {7'b0, oe}, 8'h00);
        cs_n = 1'b0; clk_wait(4);
        check1("R10 oe active", {7'b0, oe}, 8'h01);
        check1("R1 slot0 first bit", {7'b0, miso}, 8'h00);
        cs_n = 1'b1; clk_wait(8);
        check1("R10 oe released", {7'b0, oe}, 8'h00);

        set_tx(OP_ST, 8'h00, 3, 8'h00); do_frame(3, "R6 reset status");
        check1("R6 reset value", exb[2], 8'h00);
        set_tx(OP_RD, 8'h10, 7, 8'h00); do_frame(7, "R2 read from first");
        set_tx(OP_RD, 8'h1A, 6, 8'h00); do_frame(6, "R4 read past top");
        set_tx(OP_ST, 8'h00, 3, 8'h00); do_frame(3, "R4 status after overrun");
        check1("R4 status value", exb[2], 8'h04);
        set_tx(OP_RD, 8'h0F, 5, 8'h00); do_frame(5, "R5 read below window");
        set_tx(OP_ST, 8'h00, 3, 8'h00); do_frame(3, "R5 status dismiss");
        check1("R5 status value", exb[2], 8'h0C);
        set_tx(OP_WR, 8'h14, 5, 8'h3B); do_frame(5, "R3 write burst");
        set_tx(OP_RD, 8'h13, 6, 8'h00); do_frame(6, "R3 read back");
        set_tx(OP_ST, 8'h00, 3, 8'h00); do_frame(3, "R5 status clean start");
        check1("R5 dismiss cleared", exb[2], 8'h01);
        set_tx(OP_WR, 8'h1A, 6, 8'hC1); do_frame(6, "R4 write past top");
        set_tx(OP_RD, 8'h19, 6, 8'h00); do_frame(6, "R4 top after write");
        set_tx(8'h55, 8'h12, 4, 8'h77); do_frame(4, "R7 illegal opcode");
        set_tx(OP_ST, 8'h00, 3, 8'h00); do_frame(3, "R7 error set");
        check1("R7 error value", exb[2], 8'h84);
        set_tx(OP_ST, 8'h00, 3, 8'h00); do_frame(3, "R7 error cleared");
        check1("R7 cleared value", exb[2], 8'h04);
        sens = 1'b1; set_tx(OP_SV, 8'h00, 3, 8'h00); do_frame(3, "R8 sensor valid");
        sens = 1'b0; set_tx(OP_SV, 8'h00, 3, 8'h00); do_frame(3, "R8 sensor invalid");
        sens = 1'b1; set_tx(OP_ST, 8'h00, 3, 8'h00); do_frame(3, "R8 error from sensor");
        check1("R8 status value", exb[2], 8'h84);

        cs_n = 1'b0; clk_wait(HALF);
        shift_byte(OP_WR, 8, r); check1("R9 slot0", r, 8'h00);
        shift_byte(8'h12, 8, r); check1("R1 opcode echo", r, OP_WR);
        shift_byte(8'h3C, 8, r); check1("R3 address echo", r, 8'h12);
        shift_byte(8'h77, 3, r);
        clk_wait(HALF); cs_n = 1'b1; clk_wait(8);
        mem_m[2] = 8'h3C; m_dis = 0; m_fail = 1; m_valid = 0; m_err = 0;
        set_tx(OP_ST, 8'h00, 3, 8'h00); do_frame(3, "R9 cut write status");
        check1("R9 status value", exb[2], 8'h04);
        set_tx(OP_RD, 8'h12, 5, 8'h00); do_frame(5, "R9 R10 partial not stored");

        for (int t = 0; t < 40; t++) begin
            int kind, n;
            logic [7:0] op;
            kind = $urandom_range(0, 5);
            n = 2 + $urandom_range(1, 8);
            sens = 1'($urandom_range(0, 1));
            case (kind)
                0, 5: op = OP_RD;
                1: op = OP_WR;
                2: op = OP_ST;
                3: op = OP_SV;
                default: begin
                    op = 8'($urandom_range(0, 255));
                    while (op == OP_RD || op == OP_WR || op == OP_ST || op == OP_SV) op = op + 8'd1;
                end
            endcase
            txb[0] = op;
            txb[1] = 8'($urandom_range(FIRST - 3, FIRST + COUNT + 2));
            for (int i = 2; i < n; i++) txb[i] = 8'($urandom_range(0, 255));
            do_frame(n, "R1 R2 R3 R4 R7 random");
        end
        set_tx(OP_ST, 8'h00, 3, 8'h00); do_frame(3, "R6 final status");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule